// File: doc/BRIEF.md
# Boot Chip-Select Generator

This block drives the active-low select strobe of an external boot memory. It comes out of reset already decoding a 1 Mbyte window at address zero. The processor's first vector and program fetches therefore reach the boot device before any software has run. During reset the block samples one data line to learn whether the boot device is 8 or 16 bits wide. While a select is active, it counts a programmable number of wait states and then returns a data-size acknowledge that matches the captured width.

Software can reprogram the window through a two-register write port. The first register holds the base, the address-space filter and the select enable. The second holds the block size, the byte lanes, the read/write filter, the port size and the wait-state count. Registers are written into a shadow copy. The working copy is reloaded on every clock in which the address strobe is negated. A write therefore never disturbs a bus cycle already in progress, and it governs the next bus cycle that starts at least one clock after the write.

Top module: `bootsel`

## Requirements
- R1: While reset is held and on the first clock after it, `cs_n` is 1 and `dsack_n` is 2'b11.
- R2: After reset, the base is zero and the block is 1 Mbyte. Any address from 0x000000 to 0x0FFFFF selects, and 0x100000 and above do not select.
- R3: The port size is the value of `data0` on the last clock edge with reset active, and it is held after reset whatever `data0` does. A 16-bit port acknowledges with `dsack_n`=2'b01, an 8-bit port with 2'b10, and `port16` shows the size.
- R4: The select asserts with a wait count W (13 after reset). The acknowledge then appears exactly W clocks after `cs_n` falls, and stays until the address strobe negates.
- R5: `cs_n` falls on the first clock edge that samples `as_n` low with a matching access. On the first edge that samples `as_n` high, `cs_n` returns to 1 and `dsack_n` to 2'b11.
- R6: The space filter is register 0 bit 13 for user space (`fc[2]`=0) and bit 14 for supervisor space (`fc[2]`=1). Both bits are set after reset. `fc`=3'b111 never selects.
- R7: Register 0 bits 12:0 hold base address bits 23:11. Register 1 bits 3:0 hold a size code n, which gives a window of 2 Kbyte shifted left n times (reset n=9). Only address bits at or above bit 11+n are compared.
- R8: Register 1 bit 4 enables odd addresses (`addr_lsb`=1) and bit 5 enables even addresses. Both bits are set after reset, and with both clear nothing selects.
- R9: Register 0 bit 15 is the select enable, set after reset. With it clear, no access selects.
- R10: A write made during an active select changes neither that cycle's acknowledge timing nor its acknowledge value. The write applies to the next cycle.
- R11: A wait count of zero (register 1 bits 15:9) gives the acknowledge on the same edge on which the select asserts.
- R12: Register 1 bit 6 enables reads (`rw`=1) and bit 7 enables writes. Both bits are set after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_hi | input | 13 | Bus address bits 23:11 |
| addr_lsb | input | 1 | Bus address bit 0 |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code; bit 2 = supervisor, 3'b111 = CPU space |
| data0 | input | 1 | Data bit 0, sampled for port size during reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = base/space/enable register, 1 = option register |
| wr_data | input | 16 | Register write data |
| cs_n | output | 1 | Boot select, active low |
| port16 | output | 1 | Captured port size, 1 = 16 bits |
| dsack_n | output | 2 | Data-size acknowledge, active low |

## Verification
A wrong window mask or base shows at once: `cs_n` either falls on a boundary address one clock after the strobe, or fails to fall there. A mis-loaded or mis-decremented wait counter moves the acknowledge by some clocks within the same cycle. A badly captured port size flips the acknowledge code on the first cycle after reset. A stale or early working copy of the registers is caught on the cycle just after a write, including a write made in the middle of a select.

// File: rtl/bootsel.sv
module bootsel #(
  parameter int ADDR_W  = 24,
  parameter int BLK_LOG = 11,
  parameter int WS_W    = 7,
  parameter int WS_RST  = 13,
  parameter int SZ_RST  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-BLK_LOG-1:0] addr_hi,
  input  logic                      addr_lsb,
  input  logic                      as_n,
  input  logic                      rw,
  input  logic [2:0]                fc,
  input  logic                      data0,
  input  logic                      wr_en,
  input  logic                      wr_sel,
  input  logic [15:0]               wr_data,
  output logic                      cs_n,
  output logic                      port16,
  output logic [1:0]                dsack_n
);
  localparam int BASE_W = ADDR_W - BLK_LOG;

  logic [BASE_W-1:0] base_s, base_a;
  logic [1:0]        sp_s, sp_a;
  logic              en_s, en_a;
  logic [3:0]        size_s, size_a;
  logic [1:0]        byte_s, byte_a;
  logic [1:0]        rwf_s, rwf_a;
  logic              p16_s, p16_a;
  logic [WS_W-1:0]   ws_s, ws_a;
  logic [WS_W-1:0]   wcnt;
  logic              cs_q;
  logic [BASE_W-1:0] mask;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_s <= '0;
      sp_s   <= 2'b11;
      en_s   <= 1'b1;
      size_s <= 4'(SZ_RST);
      byte_s <= 2'b11;
      rwf_s  <= 2'b11;
      p16_s  <= data0;
      ws_s   <= WS_W'(WS_RST);
    end else if (wr_en) begin
      if (!wr_sel) begin
        base_s <= wr_data[BASE_W-1:0];
        sp_s   <= wr_data[14:13];
        en_s   <= wr_data[15];
      end else begin
        size_s <= wr_data[3:0];
        byte_s <= wr_data[5:4];
        rwf_s  <= wr_data[7:6];
        p16_s  <= wr_data[8];
        ws_s   <= wr_data[9 +: WS_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      sp_a   <= 2'b11;
      en_a   <= 1'b1;
      size_a <= 4'(SZ_RST);
      byte_a <= 2'b11;
      rwf_a  <= 2'b11;
      p16_a  <= data0;
      ws_a   <= WS_W'(WS_RST);
    end else if (as_n) begin
      base_a <= base_s;
      sp_a   <= sp_s;
      en_a   <= en_s;
      size_a <= size_s;
      byte_a <= byte_s;
      rwf_a  <= rwf_s;
      p16_a  <= p16_s;
      ws_a   <= ws_s;
    end
  end

  assign mask = {BASE_W{1'b1}} << size_a;

  assign hit = en_a && !as_n && (fc != 3'b111)
            && (fc[2]    ? sp_a[1]   : sp_a[0])
            && (rw       ? rwf_a[0]  : rwf_a[1])
            && (addr_lsb ? byte_a[0] : byte_a[1])
            && (((addr_hi ^ base_a) & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      cs_q <= 1'b0;
      wcnt <= '0;
    end else if (!cs_q) begin
      if (hit) begin
        cs_q <= 1'b1;
        wcnt <= ws_a;
      end
    end else if (wcnt != '0) begin
      wcnt <= wcnt - 1'b1;
    end
  end

  assign cs_n    = ~cs_q;
  assign port16  = p16_a;
  assign dsack_n = (cs_q && wcnt == '0) ? (p16_a ? 2'b01 : 2'b10) : 2'b11;
endmodule

module bootsel_chk #(
  parameter int WS_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            as_n,
  input logic            cs_n,
  input logic            port16,
  input logic [1:0]      dsack_n,
  input logic [WS_W-1:0] cnt
);
  a_r5_ack_only_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11) |-> !cs_n);

  a_r5_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (cs_n && dsack_n == 2'b11));

  a_r3_ack_code: assert property (@(posedge clk) disable iff (!rst_n)
    (dsack_n != 2'b11) |-> (dsack_n == (port16 ? 2'b01 : 2'b10)));

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !as_n && cnt != '0) |=> (!cs_n && cnt == $past(cnt) - 1'b1));

  a_r10_ack_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !as_n && dsack_n != 2'b11) |=> $stable(dsack_n));
endmodule

bind bootsel bootsel_chk #(.WS_W(WS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n),
  .port16(port16), .dsack_n(dsack_n), .cnt(wcnt)
);

// File: tb/bootsel_tb.sv
`timescale 1ns/1ps
module bootsel_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] addr_hi = '0;
  logic        addr_lsb = 0;
  logic        as_n = 1;
  logic        rw = 1;
  logic [2:0]  fc = 3'b110;
  logic        data0 = 1;
  logic        wr_en = 0;
  logic        wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic        cs_n, port16;
  logic [1:0]  dsack_n;

  int checks = 0;
  int errors = 0;

  logic [12:0] base_m;
  logic [1:0]  sp_m, byte_m, rw_m;
  logic        en_m, p16_m;
  logic [3:0]  size_m;
  int          ws_m;

  always #2 clk = ~clk;

  bootsel u_dut (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .addr_lsb(addr_lsb),
    .as_n(as_n), .rw(rw), .fc(fc), .data0(data0), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .cs_n(cs_n), .port16(port16),
    .dsack_n(dsack_n)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit mdl_hit(input logic [23:0] a, input bit r, input logic [2:0] f);
    int lg;
    bit am;
    lg = 11 + int'(size_m);
    if (lg >= 24) am = 1;
    else am = ((a >> lg) == ({base_m, 11'b0} >> lg));
    return en_m && (f != 3'b111) && (f[2] ? sp_m[1] : sp_m[0])
        && (r ? rw_m[0] : rw_m[1]) && (a[0] ? byte_m[0] : byte_m[1]) && am;
  endfunction

  function automatic logic [1:0] mdl_ack();
    return p16_m ? 2'b01 : 2'b10;
  endfunction

  task automatic do_reset(input bit d0);
    @(negedge clk);
    rst_n = 0; data0 = d0; as_n = 1; wr_en = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(cs_n == 1 && dsack_n == 2'b11, "R1 idle in reset", {cs_n, dsack_n}, 3'b111);
    @(negedge clk);
    rst_n = 1;
    data0 = ~d0;
    base_m = '0; sp_m = 2'b11; en_m = 1; size_m = 4'd9;
    byte_m = 2'b11; rw_m = 2'b11; p16_m = d0; ws_m = 13;
    @(posedge clk); #1;
    chk(cs_n == 1 && dsack_n == 2'b11, "R1 idle after reset", {cs_n, dsack_n}, 3'b111);
    chk(port16 == d0, "R3 captured port size", port16, d0);
  endtask

  task automatic reg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    @(posedge clk);
    if (!sel) begin
      base_m = d[12:0]; sp_m = d[14:13]; en_m = d[15];
    end else begin
      size_m = d[3:0]; byte_m = d[5:4]; rw_m = d[7:6]; p16_m = d[8]; ws_m = int'(d[15:9]);
    end
  endtask

  task automatic run_cycle(input string tag, input logic [23:0] a, input bit r, input logic [2:0] f);
    bit m;
    int w;
    logic [1:0] ex;
    m = mdl_hit(a, r, f);
    w = ws_m;
    ex = mdl_ack();
    @(negedge clk);
    addr_hi = a[23:11]; addr_lsb = a[0]; rw = r; fc = f; as_n = 0;
    @(posedge clk); #1;
    chk(cs_n == !m, {tag, " select decision"}, cs_n, !m);
    if (m) begin
      for (int i = 0; i <= w; i++) begin
        if (i > 0) begin @(posedge clk); #1; end
        chk(cs_n == 0 && dsack_n == ((i == w) ? ex : 2'b11), {tag, " R4 ack timing"},
            {cs_n, dsack_n}, {1'b0, ((i == w) ? ex : 2'b11)});
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(posedge clk); #1;
        chk(cs_n == 1 && dsack_n == 2'b11, {tag, " stays idle"}, {cs_n, dsack_n}, 3'b111);
      end
    end
    @(negedge clk);
    as_n = 1;
    @(posedge clk); #1;
    chk(cs_n == 1 && dsack_n == 2'b11, "R5 release", {cs_n, dsack_n}, 3'b111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(1);
    run_cycle("R2 R3 base zero read", 24'h000000, 1, 3'b110);
    run_cycle("R6 R12 top of window user write", 24'h0FFFFF, 0, 3'b001);
    run_cycle("R2 above window", 24'h100000, 1, 3'b110);
    run_cycle("R6 cpu space", 24'h000010, 1, 3'b111);

    // R10: rewrite the option register in the middle of an active select
    @(negedge clk);
    addr_hi = '0; addr_lsb = 0; rw = 1; fc = 3'b110; as_n = 0;
    @(posedge clk); #1;
    chk(cs_n == 0, "R10 select asserts", cs_n, 0);
    @(negedge clk);
    wr_en = 1; wr_sel = 1; wr_data = {7'd0, p16_m, 2'b11, 2'b00, 4'd9};
    @(posedge clk); #1;
    chk(dsack_n == 2'b11, "R10 no early ack", dsack_n, 2'b11);
    @(negedge clk);
    wr_en = 0;
    for (int i = 2; i <= 13; i++) begin
      @(posedge clk); #1;
      chk(dsack_n == ((i == 13) ? mdl_ack() : 2'b11), "R10 timing unchanged",
          dsack_n, (i == 13) ? mdl_ack() : 2'b11);
    end
    @(negedge clk);
    as_n = 1;
    @(posedge clk); #1;
    byte_m = 2'b00; ws_m = 0;
    run_cycle("R8 R10 lanes off next cycle", 24'h000000, 1, 3'b110);

    do_reset(0);
    run_cycle("R3 eight-bit port", 24'h000400, 1, 3'b101);

    reg_write(0, 16'hE200);
    reg_write(1, {7'd2, 1'b1, 2'b11, 2'b11, 4'd0});
    run_cycle("R7 new base top", 24'h1007FF, 1, 3'b110);
    run_cycle("R7 beyond 2K", 24'h100800, 1, 3'b110);
    run_cycle("R7 old base", 24'h000000, 1, 3'b110);

    reg_write(1, {7'd0, 1'b1, 2'b11, 2'b11, 4'd9});
    run_cycle("R11 zero waits", 24'h100000, 1, 3'b110);

    reg_write(1, {7'd1, 1'b1, 2'b01, 2'b11, 4'd9});
    run_cycle("R12 write blocked", 24'h100000, 0, 3'b110);
    run_cycle("R12 read allowed", 24'h100000, 1, 3'b110);
    reg_write(0, 16'hC200);
    run_cycle("R6 user blocked", 24'h100000, 1, 3'b010);
    run_cycle("R6 supervisor allowed", 24'h100000, 1, 3'b101);

    reg_write(1, {7'd1, 1'b1, 2'b11, 2'b01, 4'd9});
    run_cycle("R8 even blocked", 24'h100002, 1, 3'b110);
    run_cycle("R8 odd allowed", 24'h100003, 1, 3'b110);

    reg_write(0, 16'h6200);
    run_cycle("R9 disabled", 24'h100003, 1, 3'b110);
    reg_write(0, 16'hE200);
    run_cycle("R9 enabled again", 24'h100003, 1, 3'b110);

    for (int n = 0; n < 300; n++) begin
      logic [23:0] a;
      logic [2:0]  f;
      bit          r;
      if ($urandom % 8 == 0) begin
        if ($urandom % 2 == 0)
          reg_write(0, {($urandom % 6 != 0), 2'($urandom), 13'($urandom % 1024)});
        else
          reg_write(1, {7'($urandom % 16), 1'($urandom), 2'($urandom % 3 + 1),
                        2'($urandom % 3 + 1), 4'($urandom % 14)});
      end
      if ($urandom % 2 == 0)
        a = 24'({base_m, 11'b0} + ($urandom % (32'd2048 << size_m)));
      else
        a = 24'($urandom);
      f = 3'($urandom);
      r = 1'($urandom);
      run_cycle("R2 R7 random", a, r, f);
    end

    summary();
    $finish;
  end
endmodule